// File: doc/BRIEF.md
# Serial Flash Security Region Modify Sequencer

This block runs one erase or one program of a serial flash security region. It drives a byte-wide SPI master that is outside the block. On a request it first sets the flash write-enable latch and reads status to confirm that the latch is set. It then checks the error status register and sends the modify opcode with a four-byte address. For a program it also sends a short burst of data bytes. After that it polls status until the busy bit clears and reads the error register once more. The result is reported on a one-cycle `done` pulse, together with `error` and `bad_addr` flags.

Each command frame is framed by chip select. Chip select is low for the whole frame and high for at least one cycle between frames. For each byte the block pulses `spi_start` with `spi_tx` valid. The master answers with a one-cycle `spi_done` and the byte it received on `spi_rx`. A fallback input swaps the security-region opcodes for the plain sector erase and page program opcodes and keeps the same sequence. Polling is bounded by a count of status frames, so a flash that never finishes cannot hang the block.

Top module: `secreg_seq`

## Requirements
- R1: Every accepted request starts with a one-byte frame 06h, then a two-byte status frame 05h, 00h. The modify opcode is sent only when bit 1 (mask 0x02) of the returned status byte is set. Each second byte of a status frame is sent as 00h, and the byte received in its place is the status.
- R2: If bit 1 of the status is clear, the 06h and 05h frames are repeated once. If bit 1 is still clear, the sequence ends with `error` set and the modify opcode is not sent.
- R3: After the write-enable latch is confirmed, a frame 07h, 00h reads the error register. A nonzero reading ends the sequence with `error` set and no modify opcode.
- R4: The command frame is the opcode (44h erase, 42h program), then address bytes 31:24, 23:16, 15:8 and 7:0. A program frame adds PROG_BYTES data bytes, taken from `prog_data` while `prog_idx` gives the data byte number, counting up from 0.
- R5: A security-region erase whose address has any of bits 24..10 set sends no frame. It pulses `done` in the cycle after the request, with `error` and `bad_addr` both set. Bits 31..25 and 9..0 are not checked.
- R6: After the command frame, 05h, 00h status frames repeat until bit 0 of the received byte is 0.
- R7: If MAX_POLLS status frames in a row all return bit 0 set, the sequence ends with `error` set and no further frame. A clear bit 0 in frame MAX_POLLS still succeeds.
- R8: Once the busy bit is clear, a final 07h, 00h frame is read, and `error` is set only if that byte is nonzero.
- R9: With `fallback` high the opcodes are 20h (erase) and 02h (program), and no address range check is made.
- R10: `spi_cs_n` is low from the first byte of a frame until the `spi_done` of its last byte, and high for at least one cycle between frames. `spi_start` is only asserted while `spi_cs_n` is low.
- R11: `done` is high for exactly one cycle at the end of every sequence. `error` and `bad_addr` are valid with it and hold until the next accepted request.
- R12: A request that arrives while a sequence runs has no effect on the bytes sent or on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start pulse, sampled when idle |
| op_prog | input | 1 | 0 erase, 1 program |
| fallback | input | 1 | Use 20h/02h opcodes and skip the range check |
| addr | input | 32 | Target address |
| prog_data | input | 8 | Program data byte selected by `prog_idx` |
| prog_idx | output | IW | Index of the data byte being sent |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_start | output | 1 | Start one byte transfer |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte transfer complete |
| spi_rx | input | 8 | Byte received in that transfer |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Sequence failed |
| bad_addr | output | 1 | Request rejected for its address |

## Verification
The result flags are due in the cycle of `done`, and `done` falls one cycle later. A rejected address must give `done` exactly one cycle after the request is sampled. The bench therefore samples outputs on the falling edge and counts the falling edges from the request to `done`. The behavioural flash model lets the master answer each byte two cycles after `spi_start`. On every clock the bench compares each sent byte and each chip-select release with a queue of tokens predicted from the requirements. When `done` appears, the queue must be empty and the flags must match.

// File: rtl/secreg_seq.sv
module secreg_seq #(
  parameter int PROG_BYTES = 4,
  parameter int MAX_POLLS  = 8,
  localparam int CMD_LEN   = 5,
  localparam int FRAME_MAX = CMD_LEN + PROG_BYTES,
  localparam int IW        = $clog2(FRAME_MAX + 1),
  localparam int PW        = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          op_prog,
  input  logic          fallback,
  input  logic [31:0]   addr,
  input  logic [7:0]    prog_data,
  output logic [IW-1:0] prog_idx,
  output logic          spi_cs_n,
  output logic          spi_start,
  output logic [7:0]    spi_tx,
  input  logic          spi_done,
  input  logic [7:0]    spi_rx,
  output logic          done,
  output logic          error,
  output logic          bad_addr
);

  typedef enum logic [2:0] {S_IDLE, S_BYTE, S_WAIT, S_GAP, S_FIN} state_t;
  typedef enum logic [2:0] {F_WREN, F_RDSR, F_SR2A, F_CMD, F_POLL, F_SR2B} frame_t;

  state_t        state;
  frame_t        frame;
  logic [IW-1:0] idx, last;
  logic [7:0]    rx_last;
  logic          retried, wel_ok;
  logic [PW-1:0] poll_cnt;
  logic          op_r, fb_r;
  logic [31:0]   addr_r;
  logic [7:0]    opcode;

  wire range_bad = !op_prog && !fallback && (addr[24:10] != '0);

  assign opcode    = fb_r ? (op_r ? 8'h02 : 8'h20) : (op_r ? 8'h42 : 8'h44);
  assign spi_cs_n  = !(state == S_BYTE || state == S_WAIT);
  assign spi_start = (state == S_BYTE);
  assign done      = (state == S_FIN);
  assign prog_idx  = idx - IW'(CMD_LEN);

  always_comb begin
    case (frame)
      F_WREN:  last = '0;
      F_CMD:   last = op_r ? IW'(FRAME_MAX - 1) : IW'(CMD_LEN - 1);
      default: last = IW'(1);
    endcase
  end

  always_comb begin
    spi_tx = 8'h00;
    case (frame)
      F_WREN:         spi_tx = 8'h06;
      F_RDSR, F_POLL: spi_tx = (idx == '0) ? 8'h05 : 8'h00;
      F_SR2A, F_SR2B: spi_tx = (idx == '0) ? 8'h07 : 8'h00;
      F_CMD: begin
        case (idx)
          IW'(0):  spi_tx = opcode;
          IW'(1):  spi_tx = addr_r[31:24];
          IW'(2):  spi_tx = addr_r[23:16];
          IW'(3):  spi_tx = addr_r[15:8];
          IW'(4):  spi_tx = addr_r[7:0];
          default: spi_tx = prog_data;
        endcase
      end
      default:        spi_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      frame    <= F_WREN;
      idx      <= '0;
      rx_last  <= '0;
      retried  <= 1'b0;
      wel_ok   <= 1'b0;
      poll_cnt <= '0;
      op_r     <= 1'b0;
      fb_r     <= 1'b0;
      addr_r   <= '0;
      error    <= 1'b0;
      bad_addr <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req) begin
          op_r     <= op_prog;
          fb_r     <= fallback;
          addr_r   <= addr;
          idx      <= '0;
          frame    <= F_WREN;
          retried  <= 1'b0;
          wel_ok   <= 1'b0;
          error    <= range_bad;
          bad_addr <= range_bad;
          state    <= range_bad ? S_FIN : S_BYTE;
        end
        S_BYTE: state <= S_WAIT;
        S_WAIT: if (spi_done) begin
          rx_last <= spi_rx;
          if (idx == last) state <= S_GAP;
          else begin
            idx   <= idx + 1'b1;
            state <= S_BYTE;
          end
        end
        S_GAP: begin
          idx   <= '0;
          state <= S_BYTE;
          case (frame)
            F_WREN: frame <= F_RDSR;
            F_RDSR:
              if (rx_last[1]) begin
                wel_ok <= 1'b1;
                frame  <= F_SR2A;
              end else if (!retried) begin
                retried <= 1'b1;
                frame   <= F_WREN;
              end else begin
                error <= 1'b1;
                state <= S_FIN;
              end
            F_SR2A:
              if (rx_last != 8'h00) begin
                error <= 1'b1;
                state <= S_FIN;
              end else frame <= F_CMD;
            F_CMD: begin
              poll_cnt <= '0;
              frame    <= F_POLL;
            end
            F_POLL: begin
              poll_cnt <= poll_cnt + 1'b1;
              if (!rx_last[0]) frame <= F_SR2B;
              else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
                error <= 1'b1;
                state <= S_FIN;
              end
            end
            default: begin
              error <= (rx_last != 8'h00);
              state <= S_FIN;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_cs_n);
  assert_cs_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(spi_done));
  assert_cmd_after_wel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && frame == F_CMD && idx == '0) |-> wel_ok);
  assert_bad_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_addr) |-> done);
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> ($stable(addr_r) && $stable(op_r) && $stable(fb_r)));
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && frame == F_POLL) |-> (poll_cnt < PW'(MAX_POLLS)));

endmodule

// File: tb/secreg_seq_bench.sv
module secreg_seq_bench;
  localparam int PB = 4;
  localparam int MP = 8;
  localparam int IW = $clog2(5 + PB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, op_prog = 1'b0, fallback = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0] prog_data;
  logic [IW-1:0] prog_idx;
  logic spi_cs_n, spi_start, spi_done, done, error, bad_addr;
  logic [7:0] spi_tx, spi_rx;

  always #10 clk = ~clk;

  assign prog_data = 8'hA0 + 8'(prog_idx);

  secreg_seq #(.PROG_BYTES(PB), .MAX_POLLS(MP)) u_secreg_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .op_prog(op_prog), .fallback(fallback),
    .addr(addr), .prog_data(prog_data), .prog_idx(prog_idx), .spi_cs_n(spi_cs_n),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .done(done), .error(error), .bad_addr(bad_addr));

  int n_tests = 0, n_fail = 0;
  string cur_tag = "R1";
  logic [8:0] expq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  int cfg_wign, cfg_busy;
  logic [7:0] cfg_sr2a, cfg_sr2b;
  logic cfg_load = 1'b0;

  int wign, busy_left, fcnt, cnt;
  logic wel, started, cmd_seen, prev_cs;
  logic [7:0] fop, rx_pend;

  always @(negedge clk) begin
    spi_done <= 1'b0;
    if (cfg_load || !rst_n) begin
      wign = cfg_wign; busy_left = 0; fcnt = 0; cnt = 0;
      wel = 0; started = 0; cmd_seen = 0; prev_cs = 1; fop = 0; spi_rx <= 0;
    end else begin
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin spi_done <= 1'b1; spi_rx <= rx_pend; end
      end
      if (!prev_cs && spi_cs_n) begin
        check(expq.size() > 0 && expq[0] == 9'h100, {cur_tag, "/R10 frame end"},
              expq.size() > 0 ? int'(expq[0]) : -1, 9'h100);
        if (expq.size() > 0) void'(expq.pop_front());
        if (fop == 8'h06) begin
          if (wign > 0) wign--; else wel = 1;
        end else if (fop inside {8'h44, 8'h42, 8'h20, 8'h02}) begin
          cmd_seen = 1;
          if (wel) begin started = 1; busy_left = cfg_busy; end
        end
        fcnt = 0;
      end
      if (spi_start) begin
        check(spi_cs_n == 1'b0, "R10 start with cs low", spi_cs_n, 0);
        check(expq.size() > 0 && expq[0] == {1'b0, spi_tx}, {cur_tag, " byte"},
              spi_tx, expq.size() > 0 ? int'(expq[0]) : -1);
        if (expq.size() > 0) void'(expq.pop_front());
        if (fcnt == 0) begin fop = spi_tx; rx_pend = 8'hFF; end
        else if (fop == 8'h05) begin
          if (started && busy_left > 0) begin busy_left--; rx_pend = 8'h03; end
          else begin
            if (started) begin wel = 0; started = 0; end
            rx_pend = {6'b0, wel, 1'b0};
          end
        end else if (fop == 8'h07) rx_pend = cmd_seen ? cfg_sr2b : cfg_sr2a;
        else rx_pend = 8'hFF;
        fcnt++;
        cnt = 2;
      end
      prev_cs = spi_cs_n;
    end
  end

  task automatic push_stat(input logic [7:0] op);
    expq.push_back({1'b0, op}); expq.push_back(9'h000); expq.push_back(9'h100);
  endtask

  task automatic run_case(input string tag, input logic prg, input logic fb,
                          input logic [31:0] a, input int wf, input logic [7:0] s2a,
                          input int busy, input logic [7:0] s2b, input bit extra_req);
    logic e_err, e_bad;
    logic [7:0] opc;
    int lat, np;
    cur_tag = tag;
    cfg_wign = wf; cfg_busy = busy; cfg_sr2a = s2a; cfg_sr2b = s2b;
    @(negedge clk); cfg_load = 1; @(negedge clk); @(negedge clk); cfg_load = 0;
    expq.delete();
    e_bad = !prg && !fb && (a[24:10] != 0);
    e_err = e_bad;
    if (!e_bad) begin
      expq.push_back(9'h006); expq.push_back(9'h100); push_stat(8'h05);
      if (wf >= 1) begin expq.push_back(9'h006); expq.push_back(9'h100); push_stat(8'h05); end
      if (wf >= 2) e_err = 1;
      else begin
        push_stat(8'h07);
        if (s2a != 0) e_err = 1;
        else begin
          opc = fb ? (prg ? 8'h02 : 8'h20) : (prg ? 8'h42 : 8'h44);
          expq.push_back({1'b0, opc});
          for (int i = 0; i < 4; i++) expq.push_back({1'b0, a[31-8*i -: 8]});
          if (prg) for (int i = 0; i < PB; i++) expq.push_back({1'b0, 8'hA0 + 8'(i)});
          expq.push_back(9'h100);
          np = (busy < MP) ? busy + 1 : MP;
          for (int i = 0; i < np; i++) push_stat(8'h05);
          if (busy >= MP) e_err = 1;
          else begin push_stat(8'h07); e_err = (s2b != 0); end
        end
      end
    end
    @(negedge clk);
    req = 1; op_prog = prg; fallback = fb; addr = a;
    @(negedge clk);
    req = 0; lat = 1;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
      if (extra_req && lat == 6) begin req = 1; op_prog = ~prg; fallback = ~fb; addr = 32'hFFFF_FFFF; end
      if (extra_req && lat == 7) req = 0;
    end
    check(done == 1'b1, {tag, "/R11 done seen"}, done, 1);
    check(error == e_err, {tag, " error flag"}, error, e_err);
    check(bad_addr == e_bad, {tag, "/R5 bad_addr flag"}, bad_addr, e_bad);
    check(expq.size() == 0, {tag, " all frames sent"}, expq.size(), 0);
    if (e_bad) check(lat == 1, "R5 reject latency", lat, 1);
    @(negedge clk);
    check(done == 1'b0, "R11 done one cycle", done, 0);
    check(error == e_err && bad_addr == e_bad, "R11 flags held", {error, bad_addr}, {e_err, e_bad});
  endtask

  int cyc = 0;
  bit wd = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_start && !done && !error && !bad_addr, "R10 reset state",
              {spi_cs_n, spi_start, done, error, bad_addr}, 5'b10000);
        rst_n = 1;
        run_case("R1", 0, 0, 32'h0000_0000, 0, 8'h00, 3, 8'h00, 0);
        run_case("R4", 1, 0, 32'h0000_0800, 0, 8'h00, 2, 8'h00, 0);
        run_case("R5", 0, 0, 32'h0000_0400, 0, 8'h00, 0, 8'h00, 0);
        run_case("R5", 0, 0, 32'h0100_0000, 0, 8'h00, 0, 8'h00, 0);
        run_case("R5", 0, 0, 32'h0200_03FF, 0, 8'h00, 1, 8'h00, 0);
        run_case("R2", 0, 0, 32'h0000_0000, 1, 8'h00, 1, 8'h00, 0);
        run_case("R2", 1, 0, 32'h0000_0000, 2, 8'h00, 1, 8'h00, 0);
        run_case("R3", 0, 0, 32'h0000_0000, 0, 8'h40, 1, 8'h00, 0);
        run_case("R6", 1, 0, 32'h0000_0123, 0, 8'h00, 0, 8'h00, 0);
        run_case("R7", 0, 0, 32'h0000_0000, 0, 8'h00, 20, 8'h00, 0);
        run_case("R7", 0, 0, 32'h0000_0000, 0, 8'h00, MP - 1, 8'h00, 0);
        run_case("R8", 1, 0, 32'h0000_0000, 0, 8'h00, 2, 8'h20, 0);
        run_case("R9", 0, 1, 32'h0000_1000, 0, 8'h00, 2, 8'h00, 0);
        run_case("R9", 1, 1, 32'h00AB_CD00, 0, 8'h00, 1, 8'h00, 0);
        run_case("R12", 0, 0, 32'h0000_0000, 0, 8'h00, 3, 8'h00, 1);
      end
      begin
        wait (wd);
      end
    join_any
    if (wd) check(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule